// File: doc/BRIEF.md
# Clock-Synchronous Serial Slave Port with Ready/Busy Handshake

This block is the slave end of a four-wire clock-synchronous serial link that feeds commands, addresses and data into a memory-programming engine. An external master drives the transfer clock. The block shifts a byte in on the receive line and shifts a byte out on the transmit line during the same eight clock periods. A busy/ready line tells the master when it may begin the next byte. The transfer clock idles high, so every transfer opens with a falling edge.

On the system side the block gives a one-cycle strobe with each assembled receive byte. It holds a byte that the system loads for the next transmission. It accepts a busy request that the system raises while an erase or program operation runs. All serial lines are brought into the system clock domain through two-flop synchronizers. Edges are detected on the synchronized clock.

Top module: `sync_serial_slave`

## Requirements
- R1: Receive bits are sampled on rising edges of the transfer clock, least-significant bit first. One system clock after the eighth rising edge, `rx_byte_o` carries the assembled 8-bit byte.
- R2: The transmit line changes only after falling edges of the transfer clock. After the (k+1)-th falling edge of a transfer it carries bit k of the transmit byte, for k = 0 to 7 (LSB first).
- R3: `ser_busy_o` rises after the first falling edge of a transfer and stays high through the rest of that transfer.
- R4: While `sys_busy_i` is high, `ser_busy_o` is high. After a transfer, busy drops only once the eighth rising edge is done and `sys_busy_i` is low.
- R5: A pulse on `tx_load_i` captures `tx_byte_i` for transmission. A capture made while busy is high does not alter the byte being sent; it is used by the next transfer.
- R6: If no byte is loaded between two transfers, the second transfer sends the same byte again.
- R7: After reset, `ser_tx_o` is 1, `ser_busy_o` is 0, `rx_valid_o` is 0 and `rx_byte_o` is 0.
- R8: `rx_valid_o` is high for exactly one system clock per received byte, and it is never raised unless busy was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Transfer clock from the external master, idle high |
| ser_rx_i | input | 1 | Serial receive data |
| ser_tx_o | output | 1 | Serial transmit data, always driven |
| ser_busy_o | output | 1 | High = busy, low = ready for a transfer |
| rx_valid_o | output | 1 | One-cycle strobe with a new receive byte |
| rx_byte_o | output | 8 | Last received byte |
| tx_byte_i | input | 8 | Byte to send in the next transfer |
| tx_load_i | input | 1 | Captures `tx_byte_i` |
| sys_busy_i | input | 1 | System busy request (erase/program running) |

## Verification
The bench targets several ways the design can go wrong:
- Bit order: a receiver or transmitter that runs MSB first delivers bytes that come out bit-reversed.
- Edge choice: a transmitter that moves on the rising edge shifts its bits by one position.
- Late load: a load that lands while a transfer is running must not tear the byte that is going out. A design that copied the holding register at any moment would send the new value too early.
- Release of busy: busy held by the system across the end of a transfer checks that busy does not drop on transfer completion alone. Repeated transfers with no new load check that the previous byte is re-sent rather than zeros.

// File: rtl/sss_pkg.sv
package sss_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef enum logic {
        LINK_READY = 1'b0,
        LINK_XFER  = 1'b1
    } link_state_e;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned WIDTH   = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    assign stage_d[0] = async_i;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            assign stage_d[s] = stage_q[s-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sss_edge.sv
module sss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/sss_rx.sv
module sss_rx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         bit_i,
    output logic [W-1:0] byte_o,
    output logic         valid_o,
    output logic         done_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  shift;
        logic [CW-1:0] cnt;
        logic [W-1:0]  data;
        logic          valid;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rise_i) begin
            st_d.shift = {bit_i, st_q.shift[W-1:1]};
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                st_d.data  = {bit_i, st_q.shift[W-1:1]};
                st_d.valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign done_o  = rise_i && (st_q.cnt == LAST);
endmodule

// File: rtl/sss_tx.sv
module sss_tx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_i,
    input  logic         busy_i,
    input  logic         load_i,
    input  logic [W-1:0] load_byte_i,
    output logic         line_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  hold;
        logic [W-1:0]  shift;
        logic [CW-1:0] idx;
        logic          line;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.hold = load_byte_i;
        if (!busy_i) st_d.shift = st_q.hold;
        if (fall_i) begin
            st_d.line = st_q.shift[st_q.idx];
            st_d.idx  = (st_q.idx == LAST) ? '0 : st_q.idx + 1'b1;
        end else if (!busy_i) begin
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
endmodule

// File: rtl/sss_busy.sv
module sss_busy
    import sss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic done_i,
    input  logic sys_busy_i,
    output logic busy_o
);
    typedef struct packed {
        link_state_e state;
        logic        busy;
    } busy_state_t;

    busy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            LINK_READY: if (fall_i) st_d.state = LINK_XFER;
            LINK_XFER:  if (done_i) st_d.state = LINK_READY;
            default:    st_d.state = LINK_READY;
        endcase
        st_d.busy = (st_d.state == LINK_XFER) | sys_busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: LINK_READY, busy: 1'b0};
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/sync_serial_slave.sv
module sync_serial_slave
    import sss_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_rx_i,
    output logic              ser_tx_o,
    output logic              ser_busy_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_byte_o,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    input  logic              sys_busy_i
);
    logic [1:0] lines_sync;
    logic       rise_w, fall_w, done_w, busy_w;

    sss_sync #(.STAGES(STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_rx_i, ser_clk_i}),
        .sync_o  (lines_sync)
    );

    sss_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lines_sync[0]),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    sss_rx #(.W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .bit_i   (lines_sync[1]),
        .byte_o  (rx_byte_o),
        .valid_o (rx_valid_o),
        .done_o  (done_w)
    );

    sss_busy u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_w),
        .done_i     (done_w),
        .sys_busy_i (sys_busy_i),
        .busy_o     (busy_w)
    );

    sss_tx #(.W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (fall_w),
        .busy_i      (busy_w),
        .load_i      (tx_load_i),
        .load_byte_i (tx_byte_i),
        .line_o      (ser_tx_o)
    );

    assign ser_busy_o = busy_w;
endmodule

// File: rtl/sss_checker.sv
module sss_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic busy,
    input logic sys_busy,
    input logic tx,
    input logic fall
);
    // R8: strobe lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: strobe only closes a transfer that held busy
    a_r8_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy));

    // R4: system request forces busy
    a_r4_sys_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sys_busy |=> busy);

    // R4: busy never drops while the system request was high
    a_r4_release_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(sys_busy));

    // R3: busy rises only from a transfer start or a system request
    a_r3_busy_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(fall) || $past(sys_busy)));

    // R2: transmit line moves only after a falling edge
    a_r2_tx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx) |-> $past(fall));
endmodule

bind sync_serial_slave sss_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid_o),
    .busy     (ser_busy_o),
    .sys_busy (sys_busy_i),
    .tx       (ser_tx_o),
    .fall     (fall_w)
);

// File: tb/tb_sync_serial_slave.sv
module tb_sync_serial_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b1;
    logic       ser_rx = 1'b1;
    logic       ser_tx, ser_busy, rx_valid;
    logic [7:0] rx_byte;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic       sys_busy = 1'b0;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int pushed = 0;
    logic [7:0] rxq [$];

    always #5 clk = ~clk;

    sync_serial_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_rx_i   (ser_rx),
        .ser_tx_o   (ser_tx),
        .ser_busy_o (ser_busy),
        .rx_valid_o (rx_valid),
        .rx_byte_o  (rx_byte),
        .tx_byte_i  (tx_byte),
        .tx_load_i  (tx_load),
        .sys_busy_i (sys_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Driver: one byte each way; expected receive byte goes to the scoreboard queue
    task automatic xfer(input logic [7:0] rx_b, input logic [7:0] exp_tx, input int late_load);
        logic [7:0] got;
        got = '0;
        rxq.push_back(rx_b);
        pushed++;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ser_clk = 1'b0;
            ser_rx  = rx_b[k];
            repeat (8) @(negedge clk);
            got[k] = ser_tx;
            if (k == 0) chk("R3 busy after first fall", {31'b0, ser_busy}, 1);
            if (k == 4 && late_load >= 0) begin
                tx_byte = 8'(late_load);
                tx_load = 1'b1;
                @(negedge clk);
                tx_load = 1'b0;
            end
            if (k == 6) chk("R3 busy mid transfer", {31'b0, ser_busy}, 1);
            ser_clk = 1'b1;
            repeat (8) @(negedge clk);
        end
        chk("R2 transmit byte LSB first on falls", {24'b0, got}, {24'b0, exp_tx});
        chk("R1 receive byte on rx_byte_o", {24'b0, rx_byte}, {24'b0, rx_b});
    endtask

    // Monitor: pops the scoreboard on every strobe
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev && rx_valid) begin
                    checks++; fails++;
                    $display("FAIL R8 strobe longer than one cycle actual=1 expected=0");
                end
                if (rx_valid && !prev) begin
                    pulses++;
                    if (rxq.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R1 unexpected byte actual=%0h expected=none", rx_byte);
                    end else begin
                        chk("R1 scoreboard byte", {24'b0, rx_byte}, {24'b0, rxq.pop_front()});
                    end
                end
                prev = rx_valid;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R7 reset state
        chk("R7 tx idle high", {31'b0, ser_tx}, 1);
        chk("R7 busy low", {31'b0, ser_busy}, 0);
        chk("R7 valid low", {31'b0, rx_valid}, 0);
        chk("R7 byte zero", {24'b0, rx_byte}, 0);

        // R4 system request alone
        sys_busy = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 busy follows system request", {31'b0, ser_busy}, 1);
        sys_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 busy released", {31'b0, ser_busy}, 0);

        load_tx(8'hA5);
        repeat (4) @(negedge clk);
        xfer(8'h3C, 8'hA5, -1);
        chk("R4 ready after transfer", {31'b0, ser_busy}, 0);

        // R6 no reload -> same byte again
        xfer(8'hFF, 8'hA5, -1);
        chk("R6 ready again", {31'b0, ser_busy}, 0);

        // R5 load during transfer affects only the next
        load_tx(8'h5A);
        repeat (4) @(negedge clk);
        xfer(8'h81, 8'h5A, 'hC3);
        repeat (4) @(negedge clk);
        xfer(8'h00, 8'hC3, -1);

        // R4 system request held across end of transfer
        sys_busy = 1'b1;
        repeat (4) @(negedge clk);
        xfer(8'h6D, 8'hC3, -1);
        chk("R4 busy held by system after transfer", {31'b0, ser_busy}, 1);
        chk("R8 strobe seen while system busy", pulses, 5);
        sys_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 busy drops after system release", {31'b0, ser_busy}, 0);

        repeat (20) @(negedge clk);
        chk("R1 strobe count", pulses, pushed);
        chk("R1 scoreboard empty", rxq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule